// File: doc/BRIEF.md
# Hard/Soft Reset Sequencer with Bus-Mode Strapping

This block sits between the chip's reset network and a processor bus interface. A hard-reset request (`hreset_i`, active high, synchronous to `clk_i`) holds the bus interface idle. While it is held, every bus output group is disabled, which the pad ring turns into high impedance, and the status outputs (bus request, parity-error flags, reservation, checkstop) are forced low. The data-retry pin is sampled on the last clock of hard reset and again two clocks after release. The pair of samples selects one of three bus modes. Once the mode is resolved, the block opens the bus and raises a request for the first instruction fetch. That fetch is a single-beat, caching-inhibited load.

A hard reset shorter than `MIN_RST_CYC` clocks is rejected. The block flags it, keeps the bus closed and issues no fetch until a proper hard reset arrives. An asynchronous soft-reset pin passes through a synchronizer and an edge detector. Each assertion raises one nonmaskable system-reset exception request, which carries vector offset 0x00100 and is held until it is acknowledged. Soft-reset edges are dropped while the block is not in normal operation. A hard reset during operation discards the mode, the pending fetch and any pending exception.

Top module: `rst_cfg_ctrl`

## Requirements
- R1: Retry samples (last reset clock, second clock after release) of (0,0) give normal mode, `mode_o` = 2'd0. `mode_valid_o` and `mode_o` appear after the third rising edge that samples `hreset_i` low.
- R2: Samples (1,0), i.e. retry pulsed together with hard reset, give fast-L2 mode, `mode_o` = 2'd1.
- R3: Samples (1,1), i.e. retry held high after reset, give no-retry mode, `mode_o` = 2'd2.
- R4: Samples (0,1) fall back to normal mode, `mode_o` = 2'd0.
- R5: `bus_oe_o` is 0 and `stat_o` is all zeros while hard reset is held and until the mode is resolved. In normal operation `bus_oe_o` is 1 and `stat_o` equals `stat_i`.
- R6: When the mode is resolved, `fetch_req_o` rises with `fetch_ci_o` = 1 and `fetch_beats_o` = 1. The request holds until `fetch_ack_i` is high at a rising edge.
- R7: A hard reset held for fewer than `MIN_RST_CYC` rising edges sets `rst_bad_o` and leaves `mode_valid_o`, `fetch_req_o` and `bus_oe_o` at 0. The next hard reset clears `rst_bad_o`.
- R8: A rising edge on `sreset_i` in normal operation sets `exc_req_o` after the third rising clock edge, with `exc_vec_o` = 0x00100. Holding the pin high yields only one request.
- R9: `exc_req_o` stays high until `exc_ack_i` is high at a rising edge.
- R10: Soft-reset edges while hard reset is held or the mode is unresolved are ignored.
- R11: A hard reset during operation clears `mode_valid_o`, `fetch_req_o` and `exc_req_o` at the next rising edge.
- R12: While `rst_ni` is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| hreset_i | input | 1 | Hard-reset request, active high, synchronous |
| retry_i | input | 1 | Data-retry pin, sampled for mode strapping |
| sreset_i | input | 1 | Soft-reset pin, asynchronous, active high |
| stat_i | input | STAT_W | Status outputs from the bus engine |
| fetch_ack_i | input | 1 | Acceptance of the first-fetch request |
| exc_ack_i | input | 1 | Acceptance of the system-reset exception |
| bus_oe_o | output | 1 | Bus output enable (0 = high impedance) |
| stat_o | output | STAT_W | Gated status outputs, forced low in reset |
| mode_o | output | 2 | Selected bus mode |
| mode_valid_o | output | 1 | Mode resolved, normal operation |
| rst_bad_o | output | 1 | Last hard reset was too short |
| fetch_req_o | output | 1 | First instruction fetch request |
| fetch_beats_o | output | BEATS_W | Beat count of the fetch (1) |
| fetch_ci_o | output | 1 | Fetch is caching-inhibited |
| exc_req_o | output | 1 | System-reset exception request |
| exc_vec_o | output | VEC_W | Exception vector offset |

## Verification
A wrong retry sample or a wrong decode shows on `mode_o` in the same cycle as `mode_valid_o` rises, three edges after release. A miscounted reset length shows as `rst_bad_o` set, or wrongly left clear, in the first cycle after release. A synchronizer that is too long, too short or fails to detect edges moves or repeats `exc_req_o` relative to the three-edge latency, so the exact sample cycle catches it. Request flags that are not killed by a new hard reset stay visible one edge after `hreset_i` rises.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_FAST_L2  = 2'd1,
    MODE_NO_RETRY = 2'd2
  } bus_mode_e;

  typedef enum logic [2:0] {
    SEQ_HOLD, SEQ_WAIT1, SEQ_WAIT2, SEQ_RUN, SEQ_BAD
  } seq_state_e;

  localparam int unsigned SYS_RESET_OFS = 32'h0000_0100;

  // (sample at last reset clock, sample two clocks after release)
  function automatic bus_mode_e decode_mode(logic s_in, logic s_out);
    unique case ({s_in, s_out})
      2'b10:   return MODE_FAST_L2;
      2'b11:   return MODE_NO_RETRY;
      default: return MODE_NORMAL;
    endcase
  endfunction
endpackage

// File: rtl/rcc_sync_edge.sv
module rcc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rcc_rst_seq.sv
module rcc_rst_seq
  import rcc_pkg::*;
#(
  parameter int unsigned MIN_RST_CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hreset_i,
  input  logic      retry_i,
  output logic      run_o,
  output logic      enter_run_o,
  output logic      bad_o,
  output bus_mode_e mode_o
);
  localparam int unsigned CNT_W = $clog2(MIN_RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RST_CYC);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             smp_in_q;
  logic             bad_q;
  bus_mode_e        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_HOLD;
      cnt_q    <= '0;
      smp_in_q <= 1'b0;
      bad_q    <= 1'b0;
      mode_q   <= MODE_NORMAL;
    end else if (hreset_i) begin
      // any hard reset discards mode and restarts length count
      state_q  <= SEQ_HOLD;
      smp_in_q <= retry_i;
      bad_q    <= 1'b0;
      mode_q   <= MODE_NORMAL;
      if (state_q != SEQ_HOLD)   cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      unique case (state_q)
        SEQ_HOLD: begin
          if (cnt_q >= CNT_MAX) state_q <= SEQ_WAIT1;
          else begin
            state_q <= SEQ_BAD;
            bad_q   <= 1'b1;
          end
        end
        SEQ_WAIT1: state_q <= SEQ_WAIT2;
        SEQ_WAIT2: begin
          mode_q  <= decode_mode(smp_in_q, retry_i);
          state_q <= SEQ_RUN;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign run_o       = (state_q == SEQ_RUN);
  assign enter_run_o = (state_q == SEQ_WAIT2) && !hreset_i;
  assign bad_o       = bad_q;
  assign mode_o      = mode_q;
endmodule

// File: rtl/rcc_req_hold.sv
module rcc_req_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic set_i,
  input  logic ack_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_o <= 1'b0;
    else if (kill_i) req_o <= 1'b0;
    else if (set_i)  req_o <= 1'b1;
    else if (ack_i)  req_o <= 1'b0;
  end
endmodule

// File: rtl/rst_cfg_ctrl.sv
module rst_cfg_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned MIN_RST_CYC = 4,
  parameter int unsigned STAT_W      = 8,
  parameter int unsigned VEC_W       = 20,
  parameter int unsigned BEATS_W     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hreset_i,
  input  logic               retry_i,
  input  logic               sreset_i,
  input  logic [STAT_W-1:0]  stat_i,
  input  logic               fetch_ack_i,
  input  logic               exc_ack_i,
  output logic               bus_oe_o,
  output logic [STAT_W-1:0]  stat_o,
  output logic [1:0]         mode_o,
  output logic               mode_valid_o,
  output logic               rst_bad_o,
  output logic               fetch_req_o,
  output logic [BEATS_W-1:0] fetch_beats_o,
  output logic               fetch_ci_o,
  output logic               exc_req_o,
  output logic [VEC_W-1:0]   exc_vec_o
);
  logic      run, enter_run, bad, sr_rise;
  bus_mode_e mode;

  rcc_rst_seq #(.MIN_RST_CYC(MIN_RST_CYC)) i_seq (
    .clk_i, .rst_ni, .hreset_i, .retry_i,
    .run_o(run), .enter_run_o(enter_run), .bad_o(bad), .mode_o(mode)
  );

  rcc_sync_edge #(.STAGES(SYNC_STAGES)) i_sr_sync (
    .clk_i, .rst_ni, .async_i(sreset_i), .rise_o(sr_rise)
  );

  rcc_req_hold i_fetch_hold (
    .clk_i, .rst_ni, .kill_i(hreset_i), .set_i(enter_run),
    .ack_i(fetch_ack_i), .req_o(fetch_req_o)
  );

  // soft-reset edges count only in normal operation
  rcc_req_hold i_exc_hold (
    .clk_i, .rst_ni, .kill_i(hreset_i), .set_i(sr_rise & run),
    .ack_i(exc_ack_i), .req_o(exc_req_o)
  );

  for (genvar g = 0; g < STAT_W; g++) begin : g_stat_gate
    assign stat_o[g] = stat_i[g] & run;
  end

  assign bus_oe_o      = run;
  assign mode_valid_o  = run;
  assign mode_o        = run ? mode : 2'd0;
  assign rst_bad_o     = bad;
  assign fetch_beats_o = fetch_req_o ? BEATS_W'(1) : '0;
  assign fetch_ci_o    = fetch_req_o;
  assign exc_vec_o     = exc_req_o ? VEC_W'(SYS_RESET_OFS) : '0;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int unsigned STAT_W  = 8,
  parameter int unsigned VEC_W   = 20,
  parameter int unsigned BEATS_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hreset_i,
  input logic               exc_ack_i,
  input logic               bus_oe_o,
  input logic [STAT_W-1:0]  stat_o,
  input logic               mode_valid_o,
  input logic               rst_bad_o,
  input logic               fetch_req_o,
  input logic [BEATS_W-1:0] fetch_beats_o,
  input logic               fetch_ci_o,
  input logic               exc_req_o,
  input logic [VEC_W-1:0]   exc_vec_o
);
  assert_bus_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreset_i |=> (!bus_oe_o && stat_o == '0));

  assert_first_fetch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_valid_o) |-> (fetch_req_o && fetch_ci_o && fetch_beats_o == BEATS_W'(1)));

  assert_bad_no_fetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_bad_o |-> (!fetch_req_o && !mode_valid_o && !bus_oe_o));

  assert_exc_vector_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> exc_vec_o == VEC_W'(32'h100));

  assert_exc_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_o && !exc_ack_i && !hreset_i) |=> exc_req_o);

  assert_exc_only_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_req_o) |-> mode_valid_o);

  assert_hreset_kill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreset_i |=> (!mode_valid_o && !fetch_req_o && !exc_req_o));
endmodule

bind rst_cfg_ctrl rcc_checker #(.STAT_W(STAT_W), .VEC_W(VEC_W), .BEATS_W(BEATS_W)) i_rcc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hreset_i(hreset_i), .exc_ack_i(exc_ack_i),
  .bus_oe_o(bus_oe_o), .stat_o(stat_o), .mode_valid_o(mode_valid_o),
  .rst_bad_o(rst_bad_o), .fetch_req_o(fetch_req_o), .fetch_beats_o(fetch_beats_o),
  .fetch_ci_o(fetch_ci_o), .exc_req_o(exc_req_o), .exc_vec_o(exc_vec_o)
);

// File: tb/test_rst_cfg_ctrl.sv
module test_rst_cfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_RST    = 4;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       hreset = 1'b1, retry = 1'b0, sreset = 1'b0;
  logic [7:0] stat_i = 8'hA5;
  logic       fetch_ack = 1'b0, exc_ack = 1'b0;
  logic       bus_oe, mode_valid, rst_bad, fetch_req, fetch_ci, exc_req;
  logic [7:0] stat_o;
  logic [1:0] mode, beats;
  logic [19:0] vec;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cfg_ctrl #(.MIN_RST_CYC(MIN_RST)) i_rst_cfg_ctrl (
    .clk_i(clk), .rst_ni, .hreset_i(hreset), .retry_i(retry), .sreset_i(sreset),
    .stat_i, .fetch_ack_i(fetch_ack), .exc_ack_i(exc_ack), .bus_oe_o(bus_oe),
    .stat_o, .mode_o(mode), .mode_valid_o(mode_valid), .rst_bad_o(rst_bad),
    .fetch_req_o(fetch_req), .fetch_beats_o(beats), .fetch_ci_o(fetch_ci),
    .exc_req_o(exc_req), .exc_vec_o(vec)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // hold hard reset n edges with retry r_in, release with retry r_out
  task automatic hard_boot(int n, logic r_in, logic r_out, logic [1:0] exp_mode, string tag);
    @(negedge clk);
    hreset = 1'b1; retry = r_in;
    cyc(n);
    chk({tag, " R5 bus closed in reset"}, {bus_oe, stat_o}, 0);
    hreset = 1'b0; retry = r_out;
    cyc(2);
    chk({tag, " R5 bus closed before mode"}, {bus_oe, mode_valid}, 0);
    cyc(1);
    chk({tag, " mode valid"}, mode_valid, 1);
    chk({tag, " mode code"}, mode, exp_mode);
    retry = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R12 outputs zero in block reset",
        {bus_oe, stat_o, mode, mode_valid, rst_bad, fetch_req, beats, fetch_ci, exc_req, vec}, 0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_normal();
    hard_boot(6, 1'b0, 1'b0, 2'd0, "R1");
    chk("R5 status passes in run", {bus_oe, stat_o}, {1'b1, 8'hA5});
    chk("R6 fetch request attrs", {fetch_req, fetch_ci, beats}, {1'b1, 1'b1, 2'd1});
    cyc(3);
    chk("R6 fetch held", fetch_req, 1);
    fetch_ack = 1'b1; cyc(1); fetch_ack = 1'b0;
    chk("R6 fetch cleared by ack", fetch_req, 0);
  endtask

  task automatic t_modes();
    hard_boot(MIN_RST, 1'b1, 1'b0, 2'd1, "R2 exact min length");
    hard_boot(5, 1'b1, 1'b1, 2'd2, "R3");
    hard_boot(5, 1'b0, 1'b1, 2'd0, "R4");
  endtask

  task automatic t_short();
    @(negedge clk); hreset = 1'b1;
    cyc(MIN_RST - 1);
    hreset = 1'b0;
    cyc(1);
    chk("R7 short reset flagged", rst_bad, 1);
    cyc(3);
    chk("R7 no fetch or mode", {rst_bad, mode_valid, fetch_req, bus_oe}, 4'b1000);
    hard_boot(MIN_RST, 1'b0, 1'b0, 2'd0, "R7 recovery");
    chk("R7 flag cleared", rst_bad, 0);
  endtask

  task automatic t_sreset();
    @(negedge clk); sreset = 1'b1;
    cyc(2);
    chk("R8 no request before sync", exc_req, 0);
    cyc(1);
    chk("R8 request after sync", exc_req, 1);
    chk("R8 vector", vec, 20'h00100);
    cyc(5);
    chk("R9 held until ack", exc_req, 1);
    exc_ack = 1'b1; cyc(1); exc_ack = 1'b0;
    chk("R9 cleared by ack", exc_req, 0);
    cyc(5);
    chk("R8 one request per assertion", exc_req, 0);
    sreset = 1'b0; cyc(3);
    sreset = 1'b1; cyc(3);
    chk("R8 second assertion", exc_req, 1);
    sreset = 1'b0;
    exc_ack = 1'b1; cyc(1); exc_ack = 1'b0;
  endtask

  task automatic t_sreset_in_reset();
    @(negedge clk); hreset = 1'b1; sreset = 1'b1;
    cyc(3);
    sreset = 1'b0;
    hard_boot(MIN_RST, 1'b0, 1'b0, 2'd0, "R10 boot");
    cyc(4);
    chk("R10 edge in reset ignored", exc_req, 0);
  endtask

  task automatic t_hreset_midrun();
    sreset = 1'b1; cyc(3); sreset = 1'b0;
    chk("R11 setup exc and fetch pending", {exc_req, fetch_req, mode_valid}, 3'b111);
    hreset = 1'b1;
    cyc(1);
    chk("R11 all cleared", {exc_req, fetch_req, mode_valid, bus_oe}, 0);
    hard_boot(MIN_RST, 1'b0, 1'b0, 2'd0, "R11 reboot");
  endtask

  initial begin
    cyc(3);
    t_reset_state();
    t_normal();
    t_modes();
    t_short();
    t_sreset();
    t_sreset_in_reset();
    t_hreset_midrun();
    cyc(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule